// File: doc/BRIEF.md
# Data Cache Mode Controller

This block holds the configuration of a level-one data cache: an enable bit, a lock bit, a self-clearing flash-invalidate bit and a broadcast-enable bit. It decides, in the same cycle a load or store request is presented, whether the access is served from the cache, allocates a line on a miss, or goes out as a single-beat bus transaction that allocates nothing. It also tells the snoop logic whether snooping is on, and it raises a one-cycle flash-invalidate pulse toward the tag array.

The tag array, the data array and the bus interface are outside the block. The tag lookup result arrives as a hit flag with the request. The page's caching-inhibited attribute arrives alongside it and is passed straight to the bus side. A hard reset, including power-up, clears the configuration and invalidates every line. A soft reset clears the configuration but leaves the tag array untouched. Writes to the enable or lock bit are deferred while an access is outstanding, so that no access sees its mode change halfway through.

Top module: `dcache_mode_ctrl`

## Requirements
- R1: While hard reset is asserted and during the first cycle after its release, `flashInv` is 1. One clock edge later it is 0. The configuration read back as `cfgRdata` is 0 after hard reset, with bit 0 = enable, bit 1 = lock, bit 2 = flash-invalidate and bit 3 = broadcast.
- R2: A soft reset clears `cfgRdata` to 0 at the clock edge where it is sampled and produces no `flashInv` pulse.
- R3: A write with bit 2 set, made while bit 2 reads 0, makes `flashInv` 1 for exactly the one cycle after the write edge. If enable is 1, bit 2 reads back 1 for that cycle and 0 from the next edge onward.
- R4: While enable is 0, bit 2 stays set after a flash write. Writing 1 and then 0 in consecutive writes gives exactly one `flashInv` pulse. Writing 1 again while bit 2 already reads 1 gives no new pulse. Once enable is 1, bit 2 clears one edge later.
- R5: While enable is 0, every valid request is routed single-beat (`route` = 3), whatever the hit flag and the lock bit. Route codes are 0 none, 1 serve from cache, 2 allocate on miss, 3 single-beat.
- R6: While enabled and unlocked, a cacheable hit is routed 1 and a cacheable miss is routed 2.
- R7: While enabled and locked, a cacheable hit is routed 1 and a miss is routed 3. A locked miss never allocates, so lines lost to snoops stay invalid until the lock is released.
- R8: `cacheInhibit` equals `reqInhibit` in every mode. A valid request with the inhibit attribute is routed 3.
- R9: `snoopEn` equals the enable bit. `snoopInval` is 1 exactly when a valid snoop hits while enabled, regardless of the lock bit.
- R10: A write to the enable or lock bit with no access outstanding shows in `cfgRdata` after its edge. A write made while an access is outstanding is held. An access is outstanding from the cycle `reqValid` is high through the cycle `reqDone` is high. The held write is applied at the first edge where no access is outstanding.
- R11: The broadcast bit (bit 3) is written immediately, reads back, and drives `broadcastOn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstHardN | input | 1 | Asynchronous active-low hard reset, including power-up |
| softRst | input | 1 | Synchronous soft reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 4 | Configuration write data |
| cfgRdata | output | 4 | Configuration readback |
| reqValid | input | 1 | Load or store request present |
| reqHit | input | 1 | Tag lookup hit for the request |
| reqInhibit | input | 1 | Page caching-inhibited attribute |
| reqDone | input | 1 | Outstanding access completes this cycle |
| route | output | 2 | Routing decision for the request |
| cacheInhibit | output | 1 | Inhibit indication toward the bus |
| snoopValid | input | 1 | Snoop request present |
| snoopHit | input | 1 | Snoop tag hit |
| snoopEn | output | 1 | Snooping is active |
| snoopInval | output | 1 | Invalidate the snooped line |
| flashInv | output | 1 | One-cycle invalidate-all pulse to the tag array |
| broadcastOn | output | 1 | Cache-op broadcast enabled |

## Verification
Routing, `cacheInhibit` and the snoop outputs depend only on the inputs and the stored mode, so they are due in the same cycle as their stimulus. The bench checks them one nanosecond after driving the inputs, before the next edge. Configuration readback and the `flashInv` pulse are due one edge after the write. The auto-clear of bit 2 is due one edge after that. A deferred mode write is due one edge after the cycle in which `reqDone` ends the access. The bench advances exactly those edges and samples one nanosecond after each, so every check falls in the single cycle in which its value is due.

// File: rtl/dcache_mode_pkg.sv
package dcache_mode_pkg;
  localparam int CFG_W     = 4;
  localparam int BIT_EN    = 0;
  localparam int BIT_LOCK  = 1;
  localparam int BIT_FLASH = 2;
  localparam int BIT_BCAST = 3;
  localparam int ROUTE_W   = 2;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_NONE   = 2'd0,
    ROUTE_CACHE  = 2'd1,
    ROUTE_FILL   = 2'd2,
    ROUTE_SINGLE = 2'd3
  } route_e;

  // strobes from the control half to the routing half
  typedef struct packed {
    logic cacheOn;
    logic noAlloc;
    logic snoopOn;
  } modeStrobe_t;
endpackage

// File: rtl/dcache_mode_ctl.sv
module dcache_mode_ctl
  import dcache_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstHardN,
  input  logic             softRst,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             reqValid,
  input  logic             reqDone,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             flashInv,
  output logic             broadcastOn,
  output modeStrobe_t      strobe
);
  logic enQ, lockQ, flashQ, bcastQ;
  logic pendQ, pendEnQ, pendLockQ;
  logic inFlightQ, flashPulseQ;
  logic busyNow;

  assign busyNow = reqValid | inFlightQ;

  always_ff @(posedge clk or negedge rstHardN) begin
    if (!rstHardN) begin
      enQ <= 1'b0; lockQ <= 1'b0; flashQ <= 1'b0; bcastQ <= 1'b0;
      pendQ <= 1'b0; pendEnQ <= 1'b0; pendLockQ <= 1'b0;
      inFlightQ <= 1'b0;
      flashPulseQ <= 1'b1;            // power-up / hard reset invalidate
    end else if (softRst) begin
      enQ <= 1'b0; lockQ <= 1'b0; flashQ <= 1'b0; bcastQ <= 1'b0;
      pendQ <= 1'b0; pendEnQ <= 1'b0; pendLockQ <= 1'b0;
      inFlightQ <= 1'b0;
      flashPulseQ <= 1'b0;            // tags kept on soft reset
    end else begin
      inFlightQ   <= (inFlightQ | reqValid) & ~reqDone;
      flashPulseQ <= cfgWe & cfgWdata[BIT_FLASH] & ~flashQ;

      if (cfgWe) begin
        flashQ <= cfgWdata[BIT_FLASH];
        bcastQ <= cfgWdata[BIT_BCAST];
      end else if (flashQ && enQ) begin
        flashQ <= 1'b0;
      end

      if (cfgWe && !busyNow) begin
        enQ   <= cfgWdata[BIT_EN];
        lockQ <= cfgWdata[BIT_LOCK];
        pendQ <= 1'b0;
      end else if (cfgWe) begin
        pendQ     <= 1'b1;
        pendEnQ   <= cfgWdata[BIT_EN];
        pendLockQ <= cfgWdata[BIT_LOCK];
      end else if (pendQ && !busyNow) begin
        enQ   <= pendEnQ;
        lockQ <= pendLockQ;
        pendQ <= 1'b0;
      end
    end
  end

  always_comb begin
    cfgRdata            = '0;
    cfgRdata[BIT_EN]    = enQ;
    cfgRdata[BIT_LOCK]  = lockQ;
    cfgRdata[BIT_FLASH] = flashQ;
    cfgRdata[BIT_BCAST] = bcastQ;
  end

  assign flashInv       = flashPulseQ;
  assign broadcastOn    = bcastQ;
  assign strobe.cacheOn = enQ;
  assign strobe.noAlloc = lockQ;
  assign strobe.snoopOn = enQ;
endmodule

// File: rtl/dcache_mode_route.sv
module dcache_mode_route
  import dcache_mode_pkg::*;
(
  input  modeStrobe_t        strobe,
  input  logic               reqValid,
  input  logic               reqHit,
  input  logic               reqInhibit,
  input  logic               snoopValid,
  input  logic               snoopHit,
  output logic [ROUTE_W-1:0] route,
  output logic               cacheInhibit,
  output logic               snoopEn,
  output logic               snoopInval
);
  route_e routeSel;

  always_comb begin
    routeSel = ROUTE_NONE;
    if (reqValid) begin
      if (!strobe.cacheOn || reqInhibit) routeSel = ROUTE_SINGLE;
      else if (reqHit)                   routeSel = ROUTE_CACHE;
      else if (strobe.noAlloc)           routeSel = ROUTE_SINGLE;
      else                               routeSel = ROUTE_FILL;
    end
  end

  assign route        = routeSel;
  assign cacheInhibit = reqInhibit;
  assign snoopEn      = strobe.snoopOn;
  assign snoopInval   = snoopValid & snoopHit & strobe.snoopOn;
endmodule

// File: rtl/dcache_mode_ctrl.sv
module dcache_mode_ctrl
  import dcache_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rstHardN,
  input  logic               softRst,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgWdata,
  output logic [CFG_W-1:0]   cfgRdata,
  input  logic               reqValid,
  input  logic               reqHit,
  input  logic               reqInhibit,
  input  logic               reqDone,
  output logic [ROUTE_W-1:0] route,
  output logic               cacheInhibit,
  input  logic               snoopValid,
  input  logic               snoopHit,
  output logic               snoopEn,
  output logic               snoopInval,
  output logic               flashInv,
  output logic               broadcastOn
);
  modeStrobe_t strobe;

  dcache_mode_ctl i_ctl (
    .clk(clk), .rstHardN(rstHardN), .softRst(softRst),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqDone(reqDone),
    .cfgRdata(cfgRdata), .flashInv(flashInv),
    .broadcastOn(broadcastOn), .strobe(strobe)
  );

  dcache_mode_route i_route (
    .strobe(strobe), .reqValid(reqValid), .reqHit(reqHit),
    .reqInhibit(reqInhibit), .snoopValid(snoopValid), .snoopHit(snoopHit),
    .route(route), .cacheInhibit(cacheInhibit),
    .snoopEn(snoopEn), .snoopInval(snoopInval)
  );
endmodule

// File: rtl/dcache_mode_chk.sv
module dcache_mode_chk
  import dcache_mode_pkg::*;
(
  input logic               clk,
  input logic               rstHardN,
  input logic               softRst,
  input logic               cfgWe,
  input logic [CFG_W-1:0]   cfgRdata,
  input logic               reqValid,
  input logic               reqHit,
  input logic               reqDone,
  input logic [ROUTE_W-1:0] route,
  input logic               snoopValid,
  input logic               snoopHit,
  input logic               snoopEn,
  input logic               snoopInval,
  input logic               flashInv
);
  assert_flash_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstHardN)
    flashInv |=> !flashInv);

  assert_flash_autoclear_R3: assert property (@(posedge clk) disable iff (!rstHardN)
    (cfgRdata[BIT_FLASH] && cfgRdata[BIT_EN] && !cfgWe && !softRst) |=> !cfgRdata[BIT_FLASH]);

  assert_disabled_single_R5: assert property (@(posedge clk) disable iff (!rstHardN)
    (!cfgRdata[BIT_EN] && reqValid) |-> (route == ROUTE_SINGLE));

  assert_locked_no_alloc_R7: assert property (@(posedge clk) disable iff (!rstHardN)
    (cfgRdata[BIT_EN] && cfgRdata[BIT_LOCK] && reqValid && !reqHit) |-> (route != ROUTE_FILL));

  assert_snoop_off_R9: assert property (@(posedge clk) disable iff (!rstHardN)
    !snoopEn |-> !snoopInval);

  assert_snoop_hit_R9: assert property (@(posedge clk) disable iff (!rstHardN)
    (snoopValid && snoopHit && snoopEn) |-> snoopInval);

  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rstHardN)
    (reqValid && !reqDone && !softRst) |=> $stable(cfgRdata[BIT_LOCK:BIT_EN]));
endmodule

bind dcache_mode_ctrl dcache_mode_chk i_chk (
  .clk(clk), .rstHardN(rstHardN), .softRst(softRst), .cfgWe(cfgWe),
  .cfgRdata(cfgRdata), .reqValid(reqValid), .reqHit(reqHit),
  .reqDone(reqDone), .route(route), .snoopValid(snoopValid),
  .snoopHit(snoopHit), .snoopEn(snoopEn), .snoopInval(snoopInval),
  .flashInv(flashInv)
);

// File: tb/test_dcache_mode_ctrl.sv
`timescale 1ns/1ps
module test_dcache_mode_ctrl;
  logic clk = 1'b0;
  logic rstHardN = 1'b0, softRst = 1'b0, cfgWe = 1'b0;
  logic [3:0] cfgWdata = '0;
  logic [3:0] cfgRdata;
  logic reqValid = 1'b0, reqHit = 1'b0, reqInhibit = 1'b0, reqDone = 1'b0;
  logic [1:0] route;
  logic cacheInhibit, snoopValid = 1'b0, snoopHit = 1'b0, snoopEn, snoopInval;
  logic flashInv, broadcastOn;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dcache_mode_ctrl i_dcache_mode_ctrl (
    .clk(clk), .rstHardN(rstHardN), .softRst(softRst), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid),
    .reqHit(reqHit), .reqInhibit(reqInhibit), .reqDone(reqDone),
    .route(route), .cacheInhibit(cacheInhibit), .snoopValid(snoopValid),
    .snoopHit(snoopHit), .snoopEn(snoopEn), .snoopInval(snoopInval),
    .flashInv(flashInv), .broadcastOn(broadcastOn)
  );

  // {en, lock, inhibit, hit, expected route[1:0]}
  localparam int NV = 10;
  localparam logic [5:0] VEC [NV] = '{
    6'b0001_11, 6'b0000_11, 6'b0101_11, 6'b1001_01, 6'b1000_10,
    6'b1101_01, 6'b1100_11, 6'b1011_11, 6'b1110_11, 6'b0010_11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wcfg(input logic [3:0] d);
    cfgWe = 1'b1; cfgWdata = d;
    tick();
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 hard reset
    repeat (3) tick();
    chk("R1 flash during reset", flashInv, 1);
    rstHardN = 1'b1; #1;
    chk("R1 flash first cycle", flashInv, 1);
    chk("R1 cfg zero", cfgRdata, 0);
    tick();
    chk("R1 flash ends", flashInv, 0);

    // routing table: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      string tag;
      wcfg({2'b00, VEC[i][4], VEC[i][5]});
      reqValid = 1'b1; reqDone = 1'b1;
      reqInhibit = VEC[i][3]; reqHit = VEC[i][2];
      #1;
      if (VEC[i][3]) tag = "R8 route";
      else if (!VEC[i][5]) tag = "R5 route";
      else if (VEC[i][4]) tag = "R7 route";
      else tag = "R6 route";
      chk(tag, route, VEC[i][1:0]);
      chk("R8 inhibit passthru", cacheInhibit, VEC[i][3]);
      tick();
      reqValid = 1'b0; reqDone = 1'b0; reqHit = 1'b0; reqInhibit = 1'b0;
    end
    #1 chk("R5 idle none", route, 0);

    // R9 snoop
    wcfg(4'b0001);
    chk("R10 idle write applies", cfgRdata, 4'b0001);
    snoopValid = 1'b1; snoopHit = 1'b1; #1;
    chk("R9 snoopEn on", snoopEn, 1);
    chk("R9 inval unlocked", snoopInval, 1);
    wcfg(4'b0011); #1;
    chk("R9 inval locked", snoopInval, 1);
    wcfg(4'b0000); #1;
    chk("R9 snoopEn off", snoopEn, 0);
    chk("R9 no inval disabled", snoopInval, 0);
    snoopValid = 1'b0; snoopHit = 1'b0;

    // R3 flash while enabled
    wcfg(4'b0001);
    wcfg(4'b0101);
    chk("R3 pulse", flashInv, 1);
    chk("R3 bit set", cfgRdata[2], 1);
    tick();
    chk("R3 pulse ends", flashInv, 0);
    chk("R3 autoclear", cfgRdata[2], 0);

    // R4 flash while disabled
    wcfg(4'b0000);
    wcfg(4'b0100);
    chk("R4 pulse", flashInv, 1);
    tick();
    chk("R4 bit stays", cfgRdata[2], 1);
    wcfg(4'b0000);
    chk("R4 clear write no pulse", flashInv, 0);
    wcfg(4'b0101);
    wcfg(4'b0001);
    chk("R4 one-then-zero single pulse", flashInv, 0);
    wcfg(4'b0000);
    wcfg(4'b0100);
    tick();
    wcfg(4'b0101);
    chk("R4 rewrite no pulse", flashInv, 0);
    tick();
    chk("R4 clears once enabled", cfgRdata[2], 0);

    // R11 broadcast
    wcfg(4'b1001);
    chk("R11 readback", cfgRdata[3], 1);
    chk("R11 output", broadcastOn, 1);

    // R2 soft reset
    softRst = 1'b1; tick(); softRst = 1'b0;
    chk("R2 cfg cleared", cfgRdata, 0);
    chk("R2 no pulse", flashInv, 0);
    chk("R2 broadcast off", broadcastOn, 0);

    // R10 deferred mode write
    wcfg(4'b0001);
    reqValid = 1'b1; reqHit = 1'b1; tick();
    reqValid = 1'b0; reqHit = 1'b0;
    wcfg(4'b0011);
    chk("R10 held in flight", cfgRdata[1], 0);
    reqDone = 1'b1; tick(); reqDone = 1'b0;
    chk("R10 held on done cycle", cfgRdata[1], 0);
    tick();
    chk("R10 applied after done", cfgRdata[1], 1);
    reqValid = 1'b1; reqDone = 1'b1; reqHit = 1'b0; #1;
    chk("R7 locked miss single", route, 3);
    tick();
    reqValid = 1'b0; reqDone = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule